// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block owns the four threshold offsets used by a pair of FIFOs that carry data in opposite directions between two ports. Two of the offsets are almost-empty distances and two are almost-full distances. The block fills them once after a master reset. The mode is taken from three strap pins while reset is held: a select-program pin, a flag-select/serial-enable pin and a flag-select/serial-data pin.

There are three ways to fill the offsets. The first loads a fixed constant into all four. The second takes the first four port-A write words instead of letting them reach the FIFO storage. The third shifts a bit stream in on the port-A clock. Values outside the legal range are clamped, and an error bit records that this happened.

The block drives two ready indications, one per port. They keep both input-ready flags low until programming is complete. The port-B indication crosses into the port-B clock domain through a two-stage synchronizer.

Offset slots are numbered in programming order:
- slot 0 is the port-A almost-full offset (FIFO1);
- slot 1 is the port-B almost-empty offset (FIFO1);
- slot 2 is the port-B almost-full offset (FIFO2);
- slot 3 is the port-A almost-empty offset (FIFO2).

Top module: `ofs_loader`

## Requirements
- R1: The mode is taken from the pin levels `{sel_prog, fs1_sen, fs0_sd}` at the last `clk_a` edge while reset is held. Codes 111, 110 and 101 load all reset offsets with 64, 16 and 8 respectively.
- R2: Holding only `mrst1_n` low in a constant-load mode reloads slots 0 and 1 only. Slots 2 and 3 keep their values.
- R3: Code 100 selects word loading. The next four `wr_a` strobes load slots 0, 1, 2 and 3 in that order. Each load uses `din_a[8:0]`, with bit 8 as the MSB, and upper data bits are ignored. `ram_wr_a` stays low for these four strobes.
- R4: Once loading has finished, each `wr_a` strobe appears on `ram_wr_a` in the same cycle.
- R5: Code 010 selects serial loading. On each `clk_a` rising edge with `fs1_sen` low, one bit is taken from `fs0_sd`. There are 36 bits in total, MSB first, filling slot 0 through slot 3.
- R6: A `clk_a` edge with `fs1_sen` high takes no bit. Once serial loading is complete, further edges with `fs1_sen` low do not change any offset.
- R7: `rdy_a` is low throughout serial loading and rises at the edge that takes the last bit. `rdy_a` is high during word loading.
- R8: `rdy_a` and `rdy_b` are low while any reset is held. `rdy_b` stays low until loading completes, then rises within three `clk_b` edges.
- R9: A loaded value of 0 becomes 1, and a value above 508 becomes 508. Either case sets `cfg_err`, which holds until the next reset.
- R10: Codes 000, 011 and 001 are reserved. They act as a 64 constant load, with no programming phase.
- R11: While loading is complete, every offset lies between 1 and 508.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port-A clock |
| clk_b | input | 1 | Port-B clock |
| mrst1_n | input | 1 | Master reset of FIFO1, active low |
| mrst2_n | input | 1 | Master reset of FIFO2, active low |
| sel_prog | input | 1 | Program-select strap |
| fs1_sen | input | 1 | Flag select 1; serial enable (active low) after reset |
| fs0_sd | input | 1 | Flag select 0; serial data after reset |
| wr_a | input | 1 | Qualified port-A write strobe to FIFO1 |
| din_a | input | 36 | Port-A write data |
| ofs_y1 | output | 9 | Slot 0: port-A almost-full offset |
| ofs_x1 | output | 9 | Slot 1: port-B almost-empty offset |
| ofs_y2 | output | 9 | Slot 2: port-B almost-full offset |
| ofs_x2 | output | 9 | Slot 3: port-A almost-empty offset |
| ram_wr_a | output | 1 | Write strobe forwarded to FIFO1 storage |
| rdy_a | output | 1 | Port-A input-ready permission |
| rdy_b | output | 1 | Port-B input-ready permission (clk_b domain) |
| cfg_err | output | 1 | A loaded value was clamped |

## Verification
The hardest states to reach are the exact edge at which the serial chain completes and the partial reload of one FIFO.

For the serial case, the stimulus interleaves bit edges with random enable-high gap cycles that must take nothing. It samples the ready flag just before and just after the 36th accepted bit.

For the partial reload, the bench first fills both FIFOs with one constant. It then resets only FIFO1 under a different constant and confirms that slots 2 and 3 still hold the first value.

Random word and serial loads, some with out-of-range values, check clamping and the error bit against a bench model.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  localparam int NREG = 4;

  typedef enum logic [1:0] {
    MD_CONST,
    MD_WORD,
    MD_SERIAL,
    MD_RSVD
  } ld_mode_e;

  typedef enum logic [1:0] {
    ST_START,
    ST_WORD,
    ST_SERIAL,
    ST_DONE
  } ld_state_e;

  function automatic ld_mode_e decode_mode(input logic sel, input logic f1, input logic f0);
    if (sel) begin
      if (f1 || f0) return MD_CONST;
      return MD_WORD;
    end
    if (f1 && !f0) return MD_SERIAL;
    return MD_RSVD;
  endfunction

  // value placed in a slot while its FIFO is held in reset
  function automatic int reset_value(input logic sel, input logic f1, input logic f0);
    if (sel) begin
      case ({f1, f0})
        2'b11:   return 64;
        2'b10:   return 16;
        2'b01:   return 8;
        default: return 0;
      endcase
    end
    if (f1 && !f0) return 0;
    return 64;
  endfunction

endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_n_o = pipe_q[STAGES-1];

endmodule

// File: rtl/ofs_bit_sync.sv
module ofs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/ofs_load_ctl.sv
module ofs_load_ctl
  import ofs_pkg::*;
#(
  parameter int W    = 9,
  parameter int MAXV = 508
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ld_mode_e                mode_i,
  input  logic                    wr_i,
  input  logic [W-1:0]            din_i,
  input  logic                    sen_n_i,
  input  logic                    sd_i,
  output logic [NREG-1:0]         ld_en_o,
  output logic [NREG-1:0][W-1:0]  ld_val_o,
  output logic                    rdy_o,
  output logic                    done_o,
  output logic                    err_o
);

  localparam int SBITS = NREG * W;
  localparam int CW    = $clog2(SBITS);
  localparam logic [W-1:0]  MAXW     = W'(MAXV);
  localparam logic [CW-1:0] LAST_BIT = CW'(SBITS - 1);
  localparam logic [CW-1:0] LAST_WRD = CW'(NREG - 1);

  ld_state_e        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             err_q, err_d;
  logic [SBITS-1:0] sh_q, sh_d;
  logic             sh_en;
  logic [SBITS-1:0] ser_word;

  function automatic logic [W-1:0] clampv(input logic [W-1:0] v);
    if (v == '0)  return W'(1);
    if (v > MAXW) return MAXW;
    return v;
  endfunction

  function automatic logic badv(input logic [W-1:0] v);
    return (v == '0) || (v > MAXW);
  endfunction

  assign ser_word = {sh_q[SBITS-2:0], sd_i};
  assign sh_en    = (st_q == ST_SERIAL) && !sen_n_i;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    sh_d     = sh_q;
    ld_en_o  = '0;
    ld_val_o = '0;
    case (st_q)
      ST_START: begin
        cnt_d = '0;
        case (mode_i)
          MD_WORD:   st_d = ST_WORD;
          MD_SERIAL: st_d = ST_SERIAL;
          default:   st_d = ST_DONE;
        endcase
      end
      ST_WORD: begin
        if (wr_i) begin
          ld_en_o[cnt_q[1:0]] = 1'b1;
          for (int k = 0; k < NREG; k++) ld_val_o[k] = clampv(din_i);
          if (badv(din_i)) err_d = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_WRD) st_d = ST_DONE;
        end
      end
      ST_SERIAL: begin
        if (sh_en) begin
          sh_d  = ser_word;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            ld_en_o = '1;
            for (int k = 0; k < NREG; k++) begin
              ld_val_o[k] = clampv(ser_word[(NREG-k)*W-1 -: W]);
              if (badv(ser_word[(NREG-k)*W-1 -: W])) err_d = 1'b1;
            end
            st_d = ST_DONE;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_START;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (sh_en) sh_q <= sh_d;
  end

  assign rdy_o  = (st_q == ST_WORD) || (st_q == ST_DONE);
  assign done_o = (st_q == ST_DONE);
  assign err_o  = err_q;

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q == ST_DONE));

  // R6
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERIAL && sen_n_i) |=> $stable(cnt_q));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(|ld_en_o));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int DW          = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_a,
  input  logic                     clk_b,
  input  logic                     mrst1_n,
  input  logic                     mrst2_n,
  input  logic                     sel_prog,
  input  logic                     fs1_sen,
  input  logic                     fs0_sd,
  input  logic                     wr_a,
  input  logic [DW-1:0]            din_a,
  output logic [$clog2(DEPTH)-1:0] ofs_y1,
  output logic [$clog2(DEPTH)-1:0] ofs_x1,
  output logic [$clog2(DEPTH)-1:0] ofs_y2,
  output logic [$clog2(DEPTH)-1:0] ofs_x2,
  output logic                     ram_wr_a,
  output logic                     rdy_a,
  output logic                     rdy_b,
  output logic                     cfg_err
);

  localparam int W    = $clog2(DEPTH);
  localparam int MAXV = DEPTH - 4;

  logic [1:0]             mrst_n;
  logic [1:0]             grp_rst_n;
  logic                   rst_any_n;
  logic                   rst_b_n;
  ld_mode_e               mode_q;
  logic [W-1:0]           rst_val;
  logic [NREG-1:0]        ld_en;
  logic [NREG-1:0][W-1:0] ld_val;
  logic [NREG-1:0][W-1:0] ofs_q;
  logic                   done_a;

  assign mrst_n = {mrst2_n, mrst1_n};

  for (genvar g = 0; g < 2; g++) begin : g_rsync
    ofs_rst_sync #(.STAGES(SYNC_STAGES)) i_rsync (
      .clk     (clk_a),
      .arst_n  (mrst_n[g]),
      .rst_n_o (grp_rst_n[g])
    );
  end

  assign rst_any_n = grp_rst_n[0] & grp_rst_n[1];

  ofs_rst_sync #(.STAGES(SYNC_STAGES)) i_rsync_b (
    .clk     (clk_b),
    .arst_n  (mrst1_n & mrst2_n),
    .rst_n_o (rst_b_n)
  );

  // strap capture: the last edge seen in reset wins
  always_ff @(posedge clk_a) begin
    if (!rst_any_n) mode_q <= decode_mode(sel_prog, fs1_sen, fs0_sd);
  end

  assign rst_val = W'(reset_value(sel_prog, fs1_sen, fs0_sd));

  ofs_load_ctl #(.W(W), .MAXV(MAXV)) i_ctl (
    .clk      (clk_a),
    .rst_n    (rst_any_n),
    .mode_i   (mode_q),
    .wr_i     (wr_a),
    .din_i    (din_a[W-1:0]),
    .sen_n_i  (fs1_sen),
    .sd_i     (fs0_sd),
    .ld_en_o  (ld_en),
    .ld_val_o (ld_val),
    .rdy_o    (rdy_a),
    .done_o   (done_a),
    .err_o    (cfg_err)
  );

  // slots 0,1 belong to FIFO1, slots 2,3 to FIFO2
  for (genvar i = 0; i < NREG; i++) begin : g_slot
    always_ff @(posedge clk_a) begin
      if (!grp_rst_n[i/2]) ofs_q[i] <= rst_val;
      else if (ld_en[i])   ofs_q[i] <= ld_val[i];
    end
  end

  assign ofs_y1   = ofs_q[0];
  assign ofs_x1   = ofs_q[1];
  assign ofs_y2   = ofs_q[2];
  assign ofs_x2   = ofs_q[3];
  assign ram_wr_a = wr_a & done_a;

  ofs_bit_sync #(.STAGES(SYNC_STAGES)) i_done_sync (
    .clk   (clk_b),
    .rst_n (rst_b_n),
    .d_i   (done_a),
    .q_o   (rdy_b)
  );

  // R11
  ofs_range_chk: assert property (@(posedge clk_a) disable iff (!rst_any_n)
    done_a |-> (ofs_q[0] != '0 && ofs_q[0] <= W'(MAXV) &&
                ofs_q[1] != '0 && ofs_q[1] <= W'(MAXV) &&
                ofs_q[2] != '0 && ofs_q[2] <= W'(MAXV) &&
                ofs_q[3] != '0 && ofs_q[3] <= W'(MAXV)));

  // R8
  rdy_b_src_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    rdy_b |-> done_a);

endmodule

// File: tb/test_ofs_loader.sv
module test_ofs_loader;

  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int W    = 9;
  localparam int DW   = 36;
  localparam int MAXV = 508;
  localparam int SEED = 1234;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic mrst1_n, mrst2_n, sel_prog, fs1_sen, fs0_sd, wr_a;
  logic [DW-1:0] din_a;
  logic [W-1:0]  ofs_y1, ofs_x1, ofs_y2, ofs_x2;
  logic ram_wr_a, rdy_a, rdy_b, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int exp_v[4];
  bit exp_err;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  ofs_loader i_ofs_loader (
    .clk_a(clk_a), .clk_b(clk_b), .mrst1_n(mrst1_n), .mrst2_n(mrst2_n),
    .sel_prog(sel_prog), .fs1_sen(fs1_sen), .fs0_sd(fs0_sd), .wr_a(wr_a),
    .din_a(din_a), .ofs_y1(ofs_y1), .ofs_x1(ofs_x1), .ofs_y2(ofs_y2),
    .ofs_x2(ofs_x2), .ram_wr_a(ram_wr_a), .rdy_a(rdy_a), .rdy_b(rdy_b),
    .cfg_err(cfg_err)
  );

  function automatic int clamp_exp(input int v);
    int r = v % 512;
    if (r == 0) return 1;
    if (r > MAXV) return MAXV;
    return r;
  endfunction

  function automatic bit bad_exp(input int v);
    int r = v % 512;
    return (r == 0) || (r > MAXV);
  endfunction

  function automatic int const_exp(input bit s, input bit f1, input bit f0);
    if (s && f1 && f0) return 64;
    if (s && f1)       return 16;
    if (s && f0)       return 8;
    return 64;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " slot0"}, int'(ofs_y1), exp_v[0]);
    chk({tag, " slot1"}, int'(ofs_x1), exp_v[1]);
    chk({tag, " slot2"}, int'(ofs_y2), exp_v[2]);
    chk({tag, " slot3"}, int'(ofs_x2), exp_v[3]);
    chk({tag, " cfg_err"}, int'(cfg_err), int'(exp_err));
  endtask

  task automatic do_reset(input bit r1, input bit r2, input bit s, input bit f1, input bit f0);
    @(negedge clk_a);
    sel_prog = s; fs1_sen = f1; fs0_sd = f0; wr_a = 1'b0;
    if (r1) mrst1_n = 1'b0;
    if (r2) mrst2_n = 1'b0;
    repeat (4) @(negedge clk_a);
    chk("R8 rdy_a in reset", int'(rdy_a), 0);
    chk("R8 rdy_b in reset", int'(rdy_b), 0);
    mrst1_n = 1'b1; mrst2_n = 1'b1;
    repeat (6) @(negedge clk_a);
  endtask

  task automatic word_load(input int v[4]);
    do_reset(1, 1, 1, 0, 0);
    exp_err = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_a);
      din_a = {4'($urandom), 32'($urandom)};
      din_a[W-1:0] = W'(v[k]);
      wr_a = 1'b1;
      #1;
      chk("R3 ram_wr_a held low", int'(ram_wr_a), 0);
      chk("R7 rdy_a during word load", int'(rdy_a), 1);
      chk("R8 rdy_b before done", int'(rdy_b), 0);
      exp_v[k] = clamp_exp(v[k]);
      if (bad_exp(v[k])) exp_err = 1;
    end
    @(negedge clk_a);
    wr_a = 1'b0;
    chk_regs("R3 R9 word load");
    repeat (5) @(negedge clk_a);
    chk("R8 rdy_b after word load", int'(rdy_b), 1);
    wr_a = 1'b1;
    #1;
    chk("R4 ram_wr_a passes", int'(ram_wr_a), 1);
    @(negedge clk_a);
    wr_a = 1'b0;
    chk_regs("R4 write after load");
  endtask

  task automatic serial_load(input int v[4], input bit gaps);
    do_reset(1, 1, 0, 1, 0);
    exp_err = 0;
    for (int k = 0; k < 4; k++) begin
      exp_v[k] = clamp_exp(v[k]);
      if (bad_exp(v[k])) exp_err = 1;
    end
    for (int idx = 0; idx < 4*W; idx++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk_a);
        fs1_sen = 1'b1; fs0_sd = 1'($urandom);
      end
      @(negedge clk_a);
      if (idx == 4*W-1) begin
        chk("R7 rdy_a before last bit", int'(rdy_a), 0);
        chk("R8 rdy_b before last bit", int'(rdy_b), 0);
      end
      fs1_sen = 1'b0;
      fs0_sd = 1'(v[idx / W] >> (W - 1 - (idx % W)));
    end
    @(negedge clk_a);
    fs1_sen = 1'b1;
    chk("R7 rdy_a at last bit", int'(rdy_a), 1);
    chk_regs("R5 R6 R9 serial load");
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_a);
      fs1_sen = 1'b0; fs0_sd = 1'($urandom);
    end
    @(negedge clk_a);
    fs1_sen = 1'b1;
    chk_regs("R6 bits after completion");
    repeat (5) @(negedge clk_a);
    chk("R8 rdy_b after serial load", int'(rdy_b), 1);
  endtask

  initial begin
    #(CLK_A_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v[4];
    int dummy;
    bit cfg[6][3];
    dummy = $urandom(SEED);
    mrst1_n = 1'b0; mrst2_n = 1'b0; sel_prog = 1'b1; fs1_sen = 1'b1;
    fs0_sd = 1'b1; wr_a = 1'b0; din_a = '0;
    cfg = '{'{1,1,1}, '{1,1,0}, '{1,0,1}, '{0,0,0}, '{0,1,1}, '{0,0,1}};

    // R1 constant codes, R10 reserved codes
    for (int c = 0; c < 6; c++) begin
      do_reset(1, 1, cfg[c][0], cfg[c][1], cfg[c][2]);
      for (int k = 0; k < 4; k++) exp_v[k] = const_exp(cfg[c][0], cfg[c][1], cfg[c][2]);
      exp_err = 0;
      chk_regs(c < 3 ? "R1 constant load" : "R10 reserved code");
      chk("R1 rdy_a after constant", int'(rdy_a), 1);
      chk("R8 rdy_b after constant", int'(rdy_b), 1);
    end

    // R2 reset of FIFO1 only
    do_reset(1, 1, 1, 1, 0);
    do_reset(1, 0, 1, 0, 1);
    exp_v = '{8, 8, 16, 16};
    exp_err = 0;
    chk_regs("R2 single FIFO reload");

    // directed word loads, including clamp corners
    v = '{5, 300, 1, 508};
    word_load(v);
    v = '{0, 511, 509, 7};
    word_load(v);

    // directed serial loads
    v = '{508, 1, 255, 64};
    serial_load(v, 1);
    v = '{0, 510, 100, 3};
    serial_load(v, 0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      for (int k = 0; k < 4; k++) begin
        if ($urandom % 8 == 0) v[k] = ($urandom % 2 == 0) ? 0 : 509 + ($urandom % 3);
        else                   v[k] = 1 + ($urandom % MAXV);
      end
      if (it % 2 == 0) word_load(v);
      else             serial_load(v, 1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule